// File: doc/BRIEF.md
# Cascadable Linear-Array Scan Register

This block is the digital readout sequencer of one linear image sensor die. A start pulse is sampled on the falling edge of the shift clock and becomes a token in a chain of pixel stages. Each falling edge moves every token forward by one stage, so one pixel is selected per clock period. The active stage drives one line of a pixel-select bus, and each line stands in for one analog multiplexing switch. A binary index of the most advanced active stage comes out next to the bus.

When a token leaves the final stage, the block raises an end-of-scan pulse for one clock period. That output is meant to drive the start input of an identical neighbouring die on the same shift clock. A row of dies then reads out as one long line. Start is expected to be high across only one falling edge per scan. If it is held high longer, several tokens enter the chain, and they can be seen on the bus as adjacent active stages.

Top module: `lscan_die`

## Requirements
- R1: A synchronous reset, sampled on the falling clock edge, clears every stage and the end-of-scan output. After such an edge the select bus is all zero, the index is 0 and end-of-scan is 0. Tokens in flight are lost, including one about to leave the last stage.
- R2: If start is high at a falling edge, stage 0 (select bit 0) is active right after that edge.
- R3: On each falling edge every token moves from stage n to stage n+1, so a token loaded at edge k selects stage n after edge k+n.
- R4: For a single-edge start pulse, the select bus has exactly one bit set through the whole scan and is all zero when no token is in the chain.
- R5: The index output equals the position of the highest-numbered active stage, and it is 0 when the bus is all zero.
- R6: End-of-scan is high for exactly the one clock period that follows the edge at which a token leaves the last stage (edge k+NUM_PIXELS for a token loaded at edge k).
- R7: If start stays high across w consecutive falling edges, w tokens enter on adjacent edges. They occupy adjacent stages, and end-of-scan stays high for w periods.
- R8: Start is sampled only at falling edges. A high pulse on start that does not span a falling edge loads no token.
- R9: When end-of-scan drives the start of a second die on the same clock, the second die's stage 0 becomes active one edge after end-of-scan rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_shift | input | 1 | Shift clock. All state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, or end-of-scan of the previous die |
| pix_sel_o | output | NUM_PIXELS | Pixel-select bus, bit n selects stage n |
| pix_idx_o | output | IDX_W | Index of the most advanced active stage |
| eos_o | output | 1 | End-of-scan pulse for the next die |

## Verification
The bench goes after start pulses held across two and three edges. A chain that somehow kept only one token, or that merged tokens, would show a lone select bit and a one-period end-of-scan where two or three adjacent bits and a longer pulse are due. It also holds reset on the edge where a token would leave the last stage, which catches an end-of-scan register that escapes the reset. A start pulse that falls between two falling edges would load a stray token in a design that sampled on the rising edge or on level. The cascade check finds an off-by-one in the hand-off edge, and the index check finds an encoder that favours the lowest active stage.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

    localparam int unsigned DEF_PIXELS = 128;

    function automatic int unsigned index_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Boundary state of the chain handed to the end-of-scan stage
    typedef struct packed {
        logic last_active;
        logic first_active;
    } chain_edge_t;

endpackage

// File: rtl/lscan_chain.sv
module lscan_chain #(
    parameter int unsigned NUM_PIXELS = lscan_pkg::DEF_PIXELS
) (
    input  logic                           clk_shift,
    input  logic                           rst,
    input  logic                           start_i,
    output logic [NUM_PIXELS-1:0]          stage_o,
    output lscan_pkg::chain_edge_t         edge_o
);

    logic [NUM_PIXELS-1:0] stage_q;

    for (genvar g = 0; g < NUM_PIXELS; g++) begin : g_stage
        logic d;
        if (g == 0) begin : g_head
            assign d = start_i;
        end else begin : g_body
            assign d = stage_q[g-1];
        end
        always_ff @(negedge clk_shift) begin
            if (rst) stage_q[g] <= 1'b0;
            else     stage_q[g] <= d;
        end
    end

    assign stage_o            = stage_q;
    assign edge_o.last_active  = stage_q[NUM_PIXELS-1];
    assign edge_o.first_active = stage_q[0];

endmodule

// File: rtl/lscan_index_enc.sv
module lscan_index_enc #(
    parameter int unsigned NUM_PIXELS = lscan_pkg::DEF_PIXELS,
    localparam int unsigned IDX_W = lscan_pkg::index_bits(NUM_PIXELS)
) (
    input  logic [NUM_PIXELS-1:0] sel_i,
    output logic [IDX_W-1:0]      idx_o
);

    // Highest active stage wins, so the index tracks the leading token
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_PIXELS; i++) begin
            if (sel_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/lscan_eos.sv
module lscan_eos (
    input  logic                   clk_shift,
    input  logic                   rst,
    input  lscan_pkg::chain_edge_t edge_i,
    output logic                   eos_o
);

    always_ff @(negedge clk_shift) begin
        if (rst) eos_o <= 1'b0;
        else     eos_o <= edge_i.last_active;
    end

endmodule

// File: rtl/lscan_die.sv
module lscan_die #(
    parameter int unsigned NUM_PIXELS = lscan_pkg::DEF_PIXELS,
    localparam int unsigned IDX_W = lscan_pkg::index_bits(NUM_PIXELS)
) (
    input  logic                  clk_shift,
    input  logic                  rst,
    input  logic                  start_i,
    output logic [NUM_PIXELS-1:0] pix_sel_o,
    output logic [IDX_W-1:0]      pix_idx_o,
    output logic                  eos_o
);

    localparam int unsigned MID = NUM_PIXELS / 2;

    lscan_pkg::chain_edge_t chain_edge;

    lscan_chain #(.NUM_PIXELS(NUM_PIXELS)) u_chain (
        .clk_shift (clk_shift),
        .rst       (rst),
        .start_i   (start_i),
        .stage_o   (pix_sel_o),
        .edge_o    (chain_edge)
    );

    lscan_index_enc #(.NUM_PIXELS(NUM_PIXELS)) u_enc (
        .sel_i (pix_sel_o),
        .idx_o (pix_idx_o)
    );

    lscan_eos u_eos (
        .clk_shift (clk_shift),
        .rst       (rst),
        .edge_i    (chain_edge),
        .eos_o     (eos_o)
    );

    AST_START_LOADS: assert property (@(negedge clk_shift) disable iff (rst)
        $past(start_i) |-> pix_sel_o[0]); // R2

    AST_TOKEN_ADVANCES: assert property (@(negedge clk_shift) disable iff (rst)
        $past(pix_sel_o[MID-1]) |-> pix_sel_o[MID]); // R3

    AST_EOS_FROM_LAST: assert property (@(negedge clk_shift) disable iff (rst)
        eos_o |-> $past(pix_sel_o[NUM_PIXELS-1])); // R6

    AST_IDX_ACTIVE: assert property (@(negedge clk_shift) disable iff (rst)
        (pix_sel_o != '0) |-> pix_sel_o[pix_idx_o]); // R5

    AST_IDX_IDLE: assert property (@(negedge clk_shift) disable iff (rst)
        (pix_sel_o == '0) |-> (pix_idx_o == '0)); // R5

endmodule

// File: tb/sim_lscan_die.sv
module sim_lscan_die;

    localparam int N  = 128;
    localparam int IW = 7;
    localparam int NCASE = 5;
    // start widths (falling edges held high) walked by the main loop
    localparam int WIDTHS [NCASE] = '{1, 2, 0, 3, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N-1:0]  sel0, sel1;
    logic [IW-1:0] idx0, idx1;
    logic eos0, eos1;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lscan_die u0 (.clk_shift(clk), .rst(rst), .start_i(start),
                  .pix_sel_o(sel0), .pix_idx_o(idx0), .eos_o(eos0));
    lscan_die u1 (.clk_shift(clk), .rst(rst), .start_i(eos0),
                  .pix_sel_o(sel1), .pix_idx_o(idx1), .eos_o(eos1));

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        #2;
        tick();
        tick();
        chk_vec("R1 reset select", sel0, '0);
        chk_int("R1 reset index", int'(idx0), 0);
        chk_int("R1 reset eos", int'(eos0), 0);
        rst = 1'b0;
        tick();

        // table walk: per-edge model of token positions
        for (int c = 0; c < NCASE; c++) begin
            int w;
            w = WIDTHS[c];
            start = (w > 0);
            for (int t = 0; t <= N + w + 1; t++) begin
                logic [N-1:0] es;
                int ei;
                int ee;
                tick();
                es = '0;
                ee = 0;
                for (int j = 0; j < w; j++) begin
                    int p;
                    p = t - j;
                    if (p >= 0 && p < N) es[p] = 1'b1;
                    if (p == N) ee = 1;
                end
                ei = 0;
                for (int b = 0; b < N; b++) if (es[b]) ei = b;
                chk_vec((w > 1) ? "R7 select multi-token" : "R3/R4 select", sel0, es);
                chk_int("R5 index", int'(idx0), ei);
                chk_int((w > 1) ? "R7 eos width" : "R6 eos", int'(eos0), ee);
                if (w == 1 && t == N)
                    chk_vec("R9 cascade idle", sel1, '0);
                if (w == 1 && t == N + 1)
                    chk_vec("R9 cascade stage0", sel1, {{(N-1){1'b0}}, 1'b1});
                start = (t + 1 < w);
            end
            for (int k = 0; k < N + 4; k++) tick();
        end

        // R8: pulse between falling edges
        start = 1'b1;
        #3;
        start = 1'b0;
        tick();
        chk_vec("R8 narrow start ignored", sel0, '0);
        tick();
        chk_vec("R8 narrow start ignored later", sel0, '0);

        // R1: reset mid-scan
        start = 1'b1;
        tick();
        start = 1'b0;
        chk_vec("R2 load", sel0, {{(N-1){1'b0}}, 1'b1});
        tick(); tick(); tick();
        rst = 1'b1;
        tick();
        chk_vec("R1 mid-scan clear", sel0, '0);
        rst = 1'b0;
        tick();
        chk_vec("R1 no token after reset", sel0, '0);
        chk_int("R1 index after reset", int'(idx0), 0);

        // R1: reset on the edge a token leaves the last stage
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int k = 1; k < N; k++) tick();
        chk_int("R3 last stage reached", int'(sel0[N-1]), 1);
        chk_int("R5 index at last stage", int'(idx0), N - 1);
        rst = 1'b1;
        tick();
        chk_int("R1 eos cleared by reset", int'(eos0), 0);
        chk_vec("R1 chain cleared", sel0, '0);
        rst = 1'b0;
        tick();
        chk_int("R1 eos stays low", int'(eos0), 0);

        finish_run();
    end

endmodule